// File: doc/BRIEF.md
# Log-Magnitude Saturating Gain Stage

This block scales audio samples held in sign plus log-magnitude form. Scaling a linear amplitude by a factor becomes an addition once the amplitude is expressed as a logarithm. The stage therefore adds a gain word to the magnitude field when it amplifies, and subtracts the gain word when it attenuates. Attenuation suits wave tables whose entries already describe the loudest possible signal. The sign bit is not involved in the arithmetic and travels alongside the magnitude.

A build-time parameter picks how the stage handles overflow. In the clipping build the output keeps the input width: a sum above the largest code is held at all ones, and a difference below zero is held at zero. In the widening build the output gains one bit, so every sum is represented exactly, and subtraction still stops at zero.

Each accepted sample appears on the output one clock later, together with its own valid strobe. Between samples the output holds its last value. Reset is asserted asynchronously and active low, and it is released on a clock edge.

Top module: `log_gain_stage`

## Requirements
- R1: In amplify mode (`atten` = 0), when `in_mag + gain` fits in MAG_W bits, `out_mag` equals `in_mag + gain`.
- R2: In amplify mode in the clipping build (GROW = 0), a sum above 2^MAG_W − 1 gives `out_mag` = 2^MAG_W − 1, with all bits set. The output never wraps.
- R3: In attenuate mode (`atten` = 1), when `gain` ≤ `in_mag`, `out_mag` equals `in_mag − gain`.
- R4: In attenuate mode, when `gain` > `in_mag`, `out_mag` is 0. It never underflows.
- R5: `out_sign` equals the `in_sign` of the same sample, whatever the mode and the gain.
- R6: `out_valid` is `in_valid` delayed by exactly one clock. The result for a sample presented at clock edge k is on the outputs after edge k.
- R7: While `in_valid` is 0, `out_sign` and `out_mag` keep their previous values, whatever is on the data inputs.
- R8: After reset, `out_valid`, `out_sign` and `out_mag` are all 0.
- R9: In the widening build (GROW = 1), `out_mag` is MAG_W+1 bits wide and amplify mode returns the exact sum `in_mag + gain` without clipping.
- R10: A gain of 0 returns `in_mag` unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input sample strobe |
| in_sign | input | 1 | Sign bit of the input sample |
| in_mag | input | MAG_W | Log-magnitude of the input sample |
| gain | input | GAIN_W | Gain or attenuation amount in log units (GAIN_W ≤ MAG_W) |
| atten | input | 1 | Mode select: 0 amplifies (adds), 1 attenuates (subtracts) |
| out_valid | output | 1 | Output sample strobe |
| out_sign | output | 1 | Sign bit of the output sample |
| out_mag | output | MAG_W+GROW | Adjusted log-magnitude |

## Verification
The checker relies on two conditions on the inputs:
- `in_valid` stays low until the internal reset has been released for a few cycles.
- `gain` is no wider than the magnitude field, so one extra bit can hold any sum.

The bench meets both conditions:
- It holds every input idle for several clocks after it releases reset.
- It runs a small configuration in which gain and magnitude have the same width. In that configuration it sweeps every magnitude, every gain and both modes, through a clipping instance and a widening instance in parallel.

// File: rtl/lg_gain_pkg.sv
package lg_gain_pkg;

  typedef enum logic {
    LG_AMPLIFY = 1'b0,
    LG_ATTEN   = 1'b1
  } lg_mode_e;

  function automatic int lg_out_width(input int mag_w, input bit grow);
    return mag_w + (grow ? 1 : 0);
  endfunction

endpackage

// File: rtl/lg_rst_sync.sv
module lg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lg_mag_adjust.sv
module lg_mag_adjust
  import lg_gain_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int GAIN_W = 8,
  parameter bit GROW   = 1'b0,
  parameter int OUT_W  = MAG_W
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic [GAIN_W-1:0] gain,
  input  lg_mode_e          mode,
  output logic [OUT_W-1:0]  result
);

  localparam int EXT_W = MAG_W + 1;

  logic [EXT_W-1:0] mag_x;
  logic [EXT_W-1:0] gain_x;
  logic [EXT_W-1:0] sum_x;
  logic [EXT_W-1:0] diff_x;
  logic [MAG_W-1:0] floor_mag;
  logic [OUT_W-1:0] add_res;

  always_comb begin
    mag_x  = {1'b0, mag};
    gain_x = EXT_W'(gain);
    sum_x  = mag_x + gain_x;
    diff_x = mag_x - gain_x;
    // Both operands are below 2^MAG_W, so a set top bit marks a borrow.
    floor_mag = diff_x[MAG_W] ? '0 : diff_x[MAG_W-1:0];
  end

  generate
    if (GROW) begin : g_widen
      always_comb begin
        add_res = OUT_W'(sum_x);
      end
    end else begin : g_clip
      always_comb begin
        add_res = sum_x[MAG_W] ? '1 : OUT_W'(sum_x[MAG_W-1:0]);
      end
    end
  endgenerate

  always_comb begin
    if (mode == LG_ATTEN) begin
      result = OUT_W'(floor_mag);
    end else begin
      result = add_res;
    end
  end

endmodule

// File: rtl/lg_out_reg.sv
module lg_out_reg #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             d_sign,
  input  logic [OUT_W-1:0] d_mag,
  output logic             q_valid,
  output logic             q_sign,
  output logic [OUT_W-1:0] q_mag
);

  logic             valid_nxt;
  logic             sign_nxt;
  logic [OUT_W-1:0] mag_nxt;

  always_comb begin
    valid_nxt = load;
    sign_nxt  = q_sign;
    mag_nxt   = q_mag;
    if (load) begin
      sign_nxt = d_sign;
      mag_nxt  = d_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_sign  <= 1'b0;
      q_mag   <= '0;
    end else begin
      q_valid <= valid_nxt;
      q_sign  <= sign_nxt;
      q_mag   <= mag_nxt;
    end
  end

endmodule

// File: rtl/log_gain_stage.sv
module log_gain_stage
  import lg_gain_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int GAIN_W = 8,
  parameter bit GROW   = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_sign,
  input  logic [MAG_W-1:0]                in_mag,
  input  logic [GAIN_W-1:0]               gain,
  input  logic                            atten,
  output logic                            out_valid,
  output logic                            out_sign,
  output logic [MAG_W+(GROW ? 1 : 0)-1:0] out_mag
);

  localparam int OUT_W = lg_out_width(MAG_W, GROW);

  logic             rst_core_n;
  lg_mode_e         mode;
  logic [OUT_W-1:0] adj_mag;

  assign mode = lg_mode_e'(atten);

  lg_rst_sync #(
    .STAGES(2)
  ) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lg_mag_adjust #(
    .MAG_W  (MAG_W),
    .GAIN_W (GAIN_W),
    .GROW   (GROW),
    .OUT_W  (OUT_W)
  ) adjust_i (
    .mag    (in_mag),
    .gain   (gain),
    .mode   (mode),
    .result (adj_mag)
  );

  lg_out_reg #(
    .OUT_W(OUT_W)
  ) out_reg_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (in_valid),
    .d_sign  (in_sign),
    .d_mag   (adj_mag),
    .q_valid (out_valid),
    .q_sign  (out_sign),
    .q_mag   (out_mag)
  );

endmodule

// File: rtl/log_gain_stage_chk.sv
module log_gain_stage_chk #(
  parameter int MAG_W  = 8,
  parameter int GAIN_W = 8,
  parameter bit GROW   = 1'b0
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_sign,
  input logic [MAG_W-1:0]                in_mag,
  input logic [GAIN_W-1:0]               gain,
  input logic                            atten,
  input logic                            out_valid,
  input logic                            out_sign,
  input logic [MAG_W+(GROW ? 1 : 0)-1:0] out_mag
);

  localparam int OUT_W = MAG_W + (GROW ? 1 : 0);

  // Counts the clocks after reset release so that the internal synchronizer
  // has settled before any property is evaluated.
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
    end else if (warm_cnt != 2'd3) begin
      warm_cnt <= warm_cnt + 2'd1;
    end
  end

  assign warm = (warm_cnt == 2'd3);

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    out_valid == $past(in_valid));

  p_sign_pass_r5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    in_valid |=> out_sign == $past(in_sign));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    !in_valid |=> ($stable(out_mag) && $stable(out_sign)));

  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (in_valid && !atten) |=> out_mag >= OUT_W'($past(in_mag)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (in_valid && atten) |=> out_mag <= OUT_W'($past(in_mag)));

  p_zero_gain_r10: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (in_valid && gain == '0) |=> out_mag == OUT_W'($past(in_mag)));

endmodule

bind log_gain_stage log_gain_stage_chk #(
  .MAG_W  (MAG_W),
  .GAIN_W (GAIN_W),
  .GROW   (GROW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sign   (in_sign),
  .in_mag    (in_mag),
  .gain      (gain),
  .atten     (atten),
  .out_valid (out_valid),
  .out_sign  (out_sign),
  .out_mag   (out_mag)
);

// File: tb/log_gain_stage_tb_top.sv
module log_gain_stage_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MW         = 5;
  localparam int GW         = 5;
  localparam int MAXC       = (1 << MW) - 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_sign;
  logic [MW-1:0] in_mag;
  logic [GW-1:0] gain;
  logic          atten;

  logic          c_valid;
  logic          c_sign;
  logic [MW-1:0] c_mag;
  logic          w_valid;
  logic          w_sign;
  logic [MW:0]   w_mag;

  int checks;
  int fails;

  log_gain_stage #(.MAG_W(MW), .GAIN_W(GW), .GROW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .gain(gain), .atten(atten),
    .out_valid(c_valid), .out_sign(c_sign), .out_mag(c_mag)
  );

  log_gain_stage #(.MAG_W(MW), .GAIN_W(GW), .GROW(1'b1)) dut_g_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .gain(gain), .atten(atten),
    .out_valid(w_valid), .out_sign(w_sign), .out_mag(w_mag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic s, input int a, input int g, input logic m);
    @(negedge clk);
    in_valid = v;
    in_sign  = s;
    in_mag   = MW'(a);
    gain     = GW'(g);
    atten    = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sign  = 1'b0;
    in_mag   = '0;
    gain     = '0;
    atten    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: reset state on both builds
    chk("R8 clip valid", int'(c_valid), 0);
    chk("R8 clip sign",  int'(c_sign),  0);
    chk("R8 clip mag",   int'(c_mag),   0);
    chk("R8 wide valid", int'(w_valid), 0);
    chk("R8 wide mag",   int'(w_mag),   0);

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a <= MAXC; a++) begin
        for (int g = 0; g <= MAXC; g++) begin
          logic s;
          int   exp_c;
          int   exp_w;
          string tag;
          s = logic'((a ^ (g >> 1)) & 1);
          if (m == 1) begin
            exp_c = (a >= g) ? a - g : 0;
            exp_w = exp_c;
            tag   = (g == 0) ? "R10" : ((a >= g) ? "R3" : "R4");
          end else begin
            exp_w = a + g;
            exp_c = (a + g > MAXC) ? MAXC : a + g;
            tag   = (g == 0) ? "R10" : ((a + g > MAXC) ? "R2" : "R1");
          end
          apply(1'b1, s, a, g, logic'(m));
          chk("R6 clip valid", int'(c_valid), 1);
          chk("R6 wide valid", int'(w_valid), 1);
          chk("R5 clip sign", int'(c_sign), int'(s));
          chk("R5 wide sign", int'(w_sign), int'(s));
          chk({tag, " clip mag"}, int'(c_mag), exp_c);
          chk((m == 0) ? "R9 wide mag" : {tag, " wide mag"}, int'(w_mag), exp_w);
        end
        // R7: idle cycle with different data must not disturb the outputs
        begin
          int hold_c;
          int hold_w;
          logic hold_s;
          hold_c = int'(c_mag);
          hold_w = int'(w_mag);
          hold_s = c_sign;
          apply(1'b0, ~hold_s, MAXC - a, a, logic'(1 - m));
          chk("R6 idle valid", int'(c_valid), 0);
          chk("R7 clip hold mag", int'(c_mag), hold_c);
          chk("R7 wide hold mag", int'(w_mag), hold_w);
          chk("R7 clip hold sign", int'(c_sign), int'(hold_s));
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule